// File: doc/BRIEF.md
# Watchdog Timer with Timed Configuration Guard

This block is a watchdog timer. It counts a slow tick-enable input and fires when software has not restarted it in time. A timeout can raise an interrupt, issue a one-cycle reset pulse, or do both in stages: the interrupt comes first, and the reset follows if software does not service it. A sticky cause flag records that a watchdog reset happened, so boot code can tell why the system restarted.

The mode-enable bit and the timeout select are protected. Changing them takes two writes: an unlock write, then a commit write that must land within a short window of clock cycles. The interrupt-enable bit is not protected and takes the value of every write. A fuse-style input can pin the block to reset mode, whatever software writes.

Top module: `wdog_guard`

## Requirements
- R1: After reset, `irq_o`, `rst_pulse_o`, `cause_o`, `cfg_en_o` and `cfg_ie_o` are 0 and `cfg_psel_o` is 0.
- R2: An unlock write (`wr_i` with `wr_chg_i`=1 and `wr_en_i`=1) opens the change window. It does not itself alter `cfg_en_o` or `cfg_psel_o`.
- R3: A write with `wr_chg_i`=0 on any of the 4 clock edges that follow the unlock edge commits `wr_en_i` and `wr_psel_i`, and closes the window. The same write on the 5th edge or later leaves `cfg_en_o` and `cfg_psel_o` unchanged.
- R4: Select code n (0 to 9) gives a timeout after 2^(11+n) counted ticks. A committed code of 10 to 15 is stored as 9.
- R5: The counter advances only on clock edges where `tick_i` is 1. A `kick_i` pulse sets it back to zero, so the next timeout comes a full period after the kick.
- R6: With `cfg_ie_o`=1 and `cfg_en_o`=0, a timeout sets `irq_o` and no reset pulse is issued. `irq_o` stays high until `irq_ack_i`.
- R7: With `cfg_en_o`=1 and `cfg_ie_o`=0, a timeout drives `rst_pulse_o` high for exactly one cycle and leaves `irq_o` unchanged.
- R8: With both bits set, a timeout raises `irq_o`. Acknowledging it clears `cfg_ie_o`, so the next timeout resets. A timeout that arrives while the interrupt is still pending also resets.
- R9: While `fuse_on_i`=1, `cfg_en_o` reads 1 and `cfg_ie_o` reads 0 whatever is written, and a timeout resets.
- R10: `cause_o` is set together with the reset pulse and stays set until `cause_clr_i`.
- R11: Any write, with no unlock needed, loads `wr_ie_i` into the interrupt-enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Slow tick enable; the counter advances on clock edges where it is high |
| kick_i | input | 1 | Restart strobe from software |
| wr_i | input | 1 | Configuration write strobe |
| wr_chg_i | input | 1 | Change-enable bit of the write |
| wr_en_i | input | 1 | Reset-mode enable bit of the write |
| wr_ie_i | input | 1 | Interrupt-mode enable bit of the write |
| wr_psel_i | input | 4 | Timeout select of the write |
| irq_ack_i | input | 1 | Interrupt taken; clears `irq_o` |
| cause_clr_i | input | 1 | Clears the reset-cause flag |
| fuse_on_i | input | 1 | Forces permanent reset mode |
| irq_o | output | 1 | Interrupt request |
| rst_pulse_o | output | 1 | One-cycle watchdog reset |
| cause_o | output | 1 | Sticky watchdog-reset cause flag |
| cfg_en_o | output | 1 | Effective reset-mode enable |
| cfg_ie_o | output | 1 | Effective interrupt-mode enable |
| cfg_psel_o | output | 4 | Stored timeout select |

## Verification
The assertions check, on every cycle, the properties that involve no long timing: the protected fields hold while the window is closed, the window expires, a kick zeroes the counter, the count holds while no tick arrives, the reset pulse lasts one cycle and sets the cause flag, and the interrupt-only and fuse paths give the right response to a timeout. The bench scenarios cover the behaviour that depends on exact cycle counts: the edge-by-edge boundary of the unlock window, the period for each select code, how a kick or a stretch without ticks moves the timeout, and the interrupt-then-reset sequence in combined mode with and without an acknowledge.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int PSEL_W = 4;

  typedef struct packed {
    logic                en;
    logic                ie;
    logic [PSEL_W-1:0]   psel;
  } wdog_cfg_t;

  // codes beyond the last legal period collapse onto it
  function automatic logic [PSEL_W-1:0] clamp_sel(input logic [PSEL_W-1:0] v, input int n);
    if (int'(v) >= n) return PSEL_W'(n - 1);
    return v;
  endfunction
endpackage

// File: rtl/wdog_cfg_lock.sv
module wdog_cfg_lock
  import wdog_pkg::*;
#(
  parameter int NUM_SEL = 10,
  parameter int WIN     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              wr_chg_i,
  input  logic              wr_en_i,
  input  logic              wr_ie_i,
  input  logic [PSEL_W-1:0] wr_psel_i,
  input  logic              fuse_i,
  input  logic              ie_clr_i,
  output wdog_cfg_t         cfg_o
);
  localparam int WIN_W = $clog2(WIN + 1);

  logic [WIN_W-1:0]  win_q;
  logic              en_q, ie_q;
  logic [PSEL_W-1:0] psel_q;
  logic              open, step1, step2;

  assign open  = (win_q != '0);
  assign step1 = wr_i & wr_chg_i & wr_en_i;
  assign step2 = wr_i & ~wr_chg_i & open;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q  <= '0;
      en_q   <= 1'b0;
      ie_q   <= 1'b0;
      psel_q <= '0;
    end else begin
      if (step1)      win_q <= WIN_W'(WIN);
      else if (step2) win_q <= '0;
      else if (open)  win_q <= win_q - 1'b1;

      if (step2) begin
        en_q   <= wr_en_i;
        psel_q <= clamp_sel(wr_psel_i, NUM_SEL);
      end

      // interrupt enable is not guarded
      if (wr_i)          ie_q <= wr_ie_i;
      else if (ie_clr_i) ie_q <= 1'b0;
    end
  end

  assign cfg_o.en   = en_q | fuse_i;
  assign cfg_o.ie   = ie_q & ~fuse_i;
  assign cfg_o.psel = psel_q;

  AST_PSEL_GUARDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !open |=> $stable(psel_q)); // R3
  AST_EN_GUARDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !open |=> $stable(en_q)); // R3
  AST_WIN_EXPIRES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_q == WIN_W'(1)) && !step1 |=> !open); // R3
endmodule

// File: rtl/wdog_tick_count.sv
module wdog_tick_count
  import wdog_pkg::*;
#(
  parameter int BASE_LOG2 = 11,
  parameter int NUM_SEL   = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              tick_i,
  input  logic              kick_i,
  input  logic [PSEL_W-1:0] psel_i,
  output logic              tmo_o
);
  localparam int CNT_W = BASE_LOG2 + NUM_SEL - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   lim_tab [NUM_SEL];
  logic [CNT_W:0]   lim;
  logic             at_lim;

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_lim
    assign lim_tab[g] = (CNT_W + 1)'((64'd1 << (BASE_LOG2 + g)) - 64'd1);
  end

  assign lim    = lim_tab[psel_i];
  // >= also covers a select that shrank below the running count
  assign at_lim = ({1'b0, cnt_q} >= lim);
  assign tmo_o  = active_i & tick_i & ~kick_i & at_lim;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (!active_i || kick_i)   cnt_q <= '0;
    else if (tick_i)                cnt_q <= at_lim ? '0 : cnt_q + 1'b1;
  end

  AST_KICK_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_i |=> (cnt_q == '0)); // R5
  AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i && !tick_i && !kick_i |=> $stable(cnt_q)); // R5
endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
  import wdog_pkg::*;
#(
  parameter int BASE_LOG2 = 11,
  parameter int NUM_SEL   = 10,
  parameter int WIN       = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic        kick_i,
  input  logic        wr_i,
  input  logic        wr_chg_i,
  input  logic        wr_en_i,
  input  logic        wr_ie_i,
  input  logic [3:0]  wr_psel_i,
  input  logic        irq_ack_i,
  input  logic        cause_clr_i,
  input  logic        fuse_on_i,
  output logic        irq_o,
  output logic        rst_pulse_o,
  output logic        cause_o,
  output logic        cfg_en_o,
  output logic        cfg_ie_o,
  output logic [3:0]  cfg_psel_o
);
  wdog_cfg_t cfg;
  logic      tmo, irq_q, rst_q, cause_q;
  logic      irq_set, rst_fire, ie_clr;

  // an ack in combined mode drops interrupt enable, arming the reset stage
  assign ie_clr = irq_ack_i & irq_q & cfg.en;

  wdog_cfg_lock #(.NUM_SEL(NUM_SEL), .WIN(WIN)) u_lock (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_i),
    .wr_chg_i  (wr_chg_i),
    .wr_en_i   (wr_en_i),
    .wr_ie_i   (wr_ie_i),
    .wr_psel_i (wr_psel_i),
    .fuse_i    (fuse_on_i),
    .ie_clr_i  (ie_clr),
    .cfg_o     (cfg)
  );

  wdog_tick_count #(.BASE_LOG2(BASE_LOG2), .NUM_SEL(NUM_SEL)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (cfg.en | cfg.ie),
    .tick_i   (tick_i),
    .kick_i   (kick_i),
    .psel_i   (cfg.psel),
    .tmo_o    (tmo)
  );

  assign irq_set  = tmo & cfg.ie & ~(cfg.en & irq_q);
  assign rst_fire = tmo & cfg.en & (~cfg.ie | irq_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q   <= 1'b0;
      rst_q   <= 1'b0;
      cause_q <= 1'b0;
    end else begin
      rst_q <= rst_fire;
      if (irq_set)        irq_q <= 1'b1;
      else if (irq_ack_i) irq_q <= 1'b0;
      if (rst_fire)         cause_q <= 1'b1;
      else if (cause_clr_i) cause_q <= 1'b0;
    end
  end

  assign irq_o       = irq_q;
  assign rst_pulse_o = rst_q;
  assign cause_o     = cause_q;
  assign cfg_en_o    = cfg.en;
  assign cfg_ie_o    = cfg.ie;
  assign cfg_psel_o  = cfg.psel;

  AST_RST_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_pulse_o |=> !rst_pulse_o); // R7
  AST_CAUSE_ON_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_pulse_o |-> cause_o); // R10
  AST_IRQ_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo && cfg.ie && !cfg.en |=> irq_o && !rst_pulse_o); // R6
  AST_IRQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !irq_ack_i |=> irq_o); // R6
  AST_FUSE_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fuse_on_i && tmo |=> rst_pulse_o); // R9
endmodule

// File: tb/wdog_guard_test.sv
module wdog_guard_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1, kick = 1'b0, wr = 1'b0, wchg = 1'b0, wen = 1'b0, wie = 1'b0;
  logic [3:0] wps = '0;
  logic ack = 1'b0, cclr = 1'b0, fuse = 1'b0;
  logic irq, rst_p, cause, c_en, c_ie;
  logic [3:0] c_ps;
  int n_vec = 0, n_bad = 0, n;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wdog_guard uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .kick_i(kick), .wr_i(wr),
    .wr_chg_i(wchg), .wr_en_i(wen), .wr_ie_i(wie), .wr_psel_i(wps),
    .irq_ack_i(ack), .cause_clr_i(cclr), .fuse_on_i(fuse),
    .irq_o(irq), .rst_pulse_o(rst_p), .cause_o(cause),
    .cfg_en_o(c_en), .cfg_ie_o(c_ie), .cfg_psel_o(c_ps)
  );

  // {gap edges after unlock, select written, select expected}
  localparam logic [11:0] VEC [6] = '{
    {4'd1, 4'd3,  4'd3},
    {4'd4, 4'd5,  4'd5},
    {4'd5, 4'd7,  4'd5},
    {4'd6, 4'd2,  4'd5},
    {4'd2, 4'd12, 4'd9},
    {4'd3, 4'd0,  4'd0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr_op(input logic c, input logic e, input logic i, input logic [3:0] p, input logic k);
    wr = 1'b1; wchg = c; wen = e; wie = i; wps = p; kick = k;
    @(posedge clk); @(negedge clk);
    wr = 1'b0; wchg = 1'b0; kick = 1'b0;
  endtask

  task automatic cfg(input logic e, input logic i, input logic [3:0] p);
    wr_op(1'b1, 1'b1, i, p, 1'b0);
    wr_op(1'b0, e, i, p, 1'b1);
  endtask

  task automatic strobe_ack();
    ack = 1'b1; @(posedge clk); @(negedge clk); ack = 1'b0;
  endtask

  task automatic strobe_cclr();
    cclr = 1'b1; @(posedge clk); @(negedge clk); cclr = 1'b0;
  endtask

  task automatic meas(input bit want_irq, input int kick_at, input int lo_from, input int lo_to, output int cnt);
    cnt = 0;
    forever begin
      kick = (cnt == kick_at);
      tick = !(cnt >= lo_from && cnt < lo_to);
      @(posedge clk); cnt++; @(negedge clk);
      if ((want_irq ? irq : rst_p) || cnt >= 20000) break;
    end
    kick = 1'b0; tick = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq", irq, 0); chk("R1 rst", rst_p, 0); chk("R1 cause", cause, 0);
    chk("R1 en", c_en, 0); chk("R1 ie", c_ie, 0); chk("R1 psel", c_ps, 0);

    for (int i = 0; i < 6; i++) begin
      automatic int prev = c_ps;
      wr_op(1'b1, 1'b1, 1'b0, VEC[i][7:4] ^ 4'hF, 1'b0);
      chk("R2 unlock keeps psel", c_ps, prev);
      chk("R2 unlock keeps en", c_en, 0);
      repeat (VEC[i][11:8] - 1) @(negedge clk);
      wr_op(1'b0, 1'b0, 1'b0, VEC[i][7:4], 1'b0);
      chk("R3/R4 window commit", c_ps, VEC[i][3:0]);
    end

    cfg(1'b1, 1'b0, 4'd0);
    meas(1'b0, -1, -1, -1, n);
    chk("R7 period sel0", n, 2048);
    chk("R7 no irq", irq, 0);
    chk("R10 cause set", cause, 1);
    @(negedge clk);
    chk("R7 pulse width", rst_p, 0);
    strobe_cclr();
    chk("R10 cause cleared", cause, 0);

    cfg(1'b1, 1'b0, 4'd0);
    meas(1'b0, -1, 100, 200, n);
    chk("R5 tick gating", n, 2148);
    cfg(1'b1, 1'b0, 4'd0);
    meas(1'b0, 1000, -1, -1, n);
    chk("R5 kick restart", n, 3049);
    cfg(1'b1, 1'b0, 4'd1);
    meas(1'b0, -1, -1, -1, n);
    chk("R4 period sel1", n, 4096);
    cfg(1'b0, 1'b0, 4'd0);
    strobe_cclr();

    wr_op(1'b0, 1'b0, 1'b1, 4'd0, 1'b0);
    chk("R11 ie plain write", c_ie, 1);
    chk("R11 en untouched", c_en, 0);
    meas(1'b1, -1, -1, -1, n);
    chk("R6 irq period", n, 2048);
    chk("R6 no reset", cause, 0);
    repeat (5) @(negedge clk);
    chk("R6 irq held", irq, 1);
    strobe_ack();
    chk("R6 ack clears", irq, 0);
    chk("R6 ie kept", c_ie, 1);

    cfg(1'b1, 1'b1, 4'd0);
    meas(1'b1, -1, -1, -1, n);
    chk("R8 first stage irq", n, 2048);
    chk("R8 no reset yet", cause, 0);
    strobe_ack();
    chk("R8 ack drops ie", c_ie, 0);
    meas(1'b0, -1, -1, -1, n);
    chk("R8 second stage reset", n, 2047); // ack used one edge of the period
    cfg(1'b0, 1'b0, 4'd0);
    strobe_cclr();
    cfg(1'b1, 1'b1, 4'd0);
    meas(1'b1, -1, -1, -1, n);
    chk("R8 irq again", n, 2048);
    meas(1'b0, -1, -1, -1, n);
    chk("R8 pending irq resets", n, 2048);
    chk("R10 cause after stage", cause, 1);
    strobe_ack();
    cfg(1'b0, 1'b0, 4'd0);
    strobe_cclr();

    fuse = 1'b1;
    @(negedge clk);
    chk("R9 en forced", c_en, 1);
    chk("R9 ie forced", c_ie, 0);
    wr_op(1'b0, 1'b0, 1'b1, 4'd0, 1'b0);
    chk("R9 ie stays low", c_ie, 0);
    meas(1'b0, 0, -1, -1, n);
    chk("R9 fuse reset", n, 2049);
    chk("R9 no irq", irq, 0);
    fuse = 1'b0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule